// File: doc/BRIEF.md
# Flash Command Decoder

This block sits between a parallel memory bus and the program/erase engine of a flash-style memory. It watches the chip-enable, write-enable and output-enable pins and treats each completed write as a command byte (or, for two-cycle sequences, as the address and data of an operation). From the commands it keeps track of which source a read should return: array contents, identifier data, the status byte or query data. It drives a two-bit read-select code that the read data path uses to pick that source.

Program and erase each take two writes. The first write arms the sequence. The second write supplies the target address and, for a program, the data word. The finished request goes to the execution engine over a valid/ready handoff. The engine reports completion with a one-cycle done pulse. A running operation can be suspended and later resumed. While an erase is suspended, a single program may be run. After any operation, reads keep returning status until a read-array command is written.

All pins are sampled on `clk`. The bus pins are assumed to be already synchronous to that clock. Array storage and the internal timing of the operations live outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After `rst_n` has been released, `rd_sel` is 0 (array), `status` is 80h, `op_valid` is low and `op_suspend` is low.
- R2: A write cycle is live while `ce_n` and `we_n` are both low and `oe_n` is high. Its address and data are taken when the first of `ce_n`/`we_n` rises, and each cycle is taken exactly once. A cycle during which `oe_n` is low has no effect.
- R3: Command bytes are taken from `wdata[7:0]`. The byte values FFh, 90h, 98h and 70h select `rd_sel` codes 0 (array), 1 (configuration), 3 (query) and 2 (status). An unrecognised byte changes neither `rd_sel` nor `status`.
- R4: The byte 40h arms a program, and the next write starts it: `op_kind` is 0, `op_addr` is that write's address and `op_data` is its whole data word. Both writes leave `rd_sel` at 2.
- R5: The byte 20h arms an erase. A next write of D0h starts it, with `op_kind` 1 and the address of the D0h write. Any other next byte starts nothing, sets status bit 5 and leaves `rd_sel` at 2. The byte 50h, written when idle, clears bit 5.
- R6: `op_valid` stays high, with `op_kind`, `op_addr` and `op_data` unchanged, until a cycle in which `op_ready` is high. It falls after that cycle.
- R7: The `status` byte is laid out as follows: bit 7 is high when no operation is running, bit 6 marks a suspended erase, bit 5 is the sequence error and bit 2 marks a suspended program. All other bits are 0. After an `eng_done` pulse, `rd_sel` stays 2 until FFh is written.
- R8: While an operation is running, only 70h and B0h have an effect. Every other write is ignored.
- R9: B0h, written once the engine has accepted the running operation, raises `op_suspend`, and D0h lowers it again. While suspended, FFh, 90h, 98h and 70h change the read mode. After an erase suspend, 40h may start one program; `op_suspend` stays high during that program, and the program's done pulse returns the block to the suspended erase. Every other command is ignored while suspended.
- R10: A write that only carries a command never raises `op_valid`. Only the second write of a program or erase sequence raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data; command byte in bits 7:0 |
| rd_sel | output | 2 | Read source: 0 array, 1 configuration, 2 status, 3 query |
| status | output | 8 | Status byte |
| op_valid | output | 1 | Operation request valid |
| op_ready | input | 1 | Engine accepts the request |
| op_kind | output | 1 | 0 program, 1 erase |
| op_addr | output | AW | Target address of the request |
| op_data | output | DW | Program data of the request |
| op_suspend | output | 1 | Engine must hold the operation |
| eng_done | input | 1 | One-cycle pulse when the running operation ends |

## Verification
The hardest state to reach from the ports is a program running inside a suspended erase. Getting there takes a run of steps. First an erase must be armed and confirmed, and the engine must accept it. Then the suspend command is written, followed by a read-array command and a second program sequence. Finally a done pulse must return the block to the suspended erase and not to idle. The bench drives that exact run with its engine-side pulses and checks `status` at every step (40h while the program runs, C0h once the erase is held again). A cycle that ends on the chip-enable edge while write enable stays low is also forced. A double capture of an erase-setup byte would then show up as a sequence error.

// File: rtl/flash_cui_pkg.sv
`timescale 1ns/1ps
package flash_cui_pkg;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_CFG   = 8'h90;
  localparam logic [7:0] CMD_READ_QUERY = 8'h98;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_PGM_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERS_SETUP  = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;

  localparam logic KIND_PROGRAM = 1'b0;
  localparam logic KIND_ERASE   = 1'b1;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_CONFIG = 2'd1,
    RD_STATUS = 2'd2,
    RD_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2,
    ST_NEST = 2'd3
  } op_st_e;

  typedef enum logic [1:0] {
    P_NONE = 2'd0,
    P_PGM  = 2'd1,
    P_ERS  = 2'd2
  } pend_e;
endpackage

// File: rtl/cui_bus_capture.sv
`timescale 1ns/1ps
module cui_bus_capture #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          live;
  logic          live_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign live = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      live_q <= live;
      if (live) begin
        addr_q <= addr;
        data_q <= wdata;
      end
    end
  end

  // the first enable edge to rise ends the cycle
  assign wr_stb  = live_q && (ce_n || we_n);
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R2: a strobe only follows a cycle that was live on the pins
  p_commit_after_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(!ce_n && !we_n && oe_n));

  // R2: one cycle yields one strobe
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/cui_cmd_fsm.sv
`timescale 1ns/1ps
module cui_cmd_fsm
  import flash_cui_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          op_ready,
  input  logic          eng_done,
  output logic          op_valid,
  output logic          op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          op_suspend,
  output logic          mode_we,
  output rd_mode_e      mode_val,
  output logic          set_err,
  output logic          clr_err,
  output logic          ready,
  output logic          erase_held,
  output logic          prog_held
);
  op_st_e        st_q, st_d, st_eff;
  pend_e         pend_q, pend_d;
  logic          se_q, se_d;
  logic          start;
  logic          start_kind;
  logic          valid_q;
  logic          kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [7:0]    cmd;

  assign cmd = wr_data[7:0];

  always_comb begin
    st_eff = st_q;
    if (eng_done) begin
      if (st_q == ST_RUN)       st_eff = ST_IDLE;
      else if (st_q == ST_NEST) st_eff = ST_SUSP;
    end
    st_d       = st_eff;
    pend_d     = pend_q;
    se_d       = se_q;
    start      = 1'b0;
    start_kind = KIND_PROGRAM;
    mode_we    = 1'b0;
    mode_val   = RD_STATUS;
    set_err    = 1'b0;
    clr_err    = 1'b0;
    if (wr_stb) begin
      if (pend_q != P_NONE) begin
        pend_d  = P_NONE;
        mode_we = 1'b1;
        if (pend_q == P_PGM) begin
          start = 1'b1;
          st_d  = (st_eff == ST_SUSP) ? ST_NEST : ST_RUN;
        end else if (cmd == CMD_CONFIRM) begin
          start      = 1'b1;
          start_kind = KIND_ERASE;
          st_d       = ST_RUN;
        end else begin
          set_err = 1'b1;
        end
      end else begin
        case (st_eff)
          ST_IDLE, ST_SUSP: begin
            case (cmd)
              CMD_READ_ARRAY: begin mode_we = 1'b1; mode_val = RD_ARRAY;  end
              CMD_READ_CFG:   begin mode_we = 1'b1; mode_val = RD_CONFIG; end
              CMD_READ_QUERY: begin mode_we = 1'b1; mode_val = RD_QUERY;  end
              CMD_READ_STAT:  mode_we = 1'b1;
              CMD_PGM_SETUP: begin
                if (st_eff == ST_IDLE || se_q) begin
                  pend_d  = P_PGM;
                  mode_we = 1'b1;
                end
              end
              CMD_ERS_SETUP: begin
                if (st_eff == ST_IDLE) begin
                  pend_d  = P_ERS;
                  mode_we = 1'b1;
                end
              end
              CMD_CLR_STAT: begin
                if (st_eff == ST_IDLE) clr_err = 1'b1;
              end
              CMD_CONFIRM: begin
                if (st_eff == ST_SUSP) begin
                  st_d    = ST_RUN;
                  mode_we = 1'b1;
                end
              end
              default: ;
            endcase
          end
          ST_RUN: begin
            if (cmd == CMD_READ_STAT) begin
              mode_we = 1'b1;
            end else if (cmd == CMD_SUSPEND && !valid_q) begin
              st_d    = ST_SUSP;
              se_d    = (kind_q == KIND_ERASE);
              mode_we = 1'b1;
            end
          end
          ST_NEST: begin
            if (cmd == CMD_READ_STAT) mode_we = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= P_NONE;
      se_q    <= 1'b0;
      valid_q <= 1'b0;
      kind_q  <= KIND_PROGRAM;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      se_q   <= se_d;
      if (start) begin
        valid_q <= 1'b1;
        kind_q  <= start_kind;
        addr_q  <= wr_addr;
        data_q  <= wr_data;
      end else if (valid_q && op_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign op_valid   = valid_q;
  assign op_kind    = kind_q;
  assign op_addr    = addr_q;
  assign op_data    = data_q;
  assign op_suspend = (st_q == ST_SUSP) || (st_q == ST_NEST);
  assign ready      = (st_q == ST_IDLE) || (st_q == ST_SUSP);
  assign erase_held = se_q && ((st_q == ST_SUSP) || (st_q == ST_NEST));
  assign prog_held  = !se_q && (st_q == ST_SUSP);

  // R6: the request holds steady under back-pressure
  p_hold_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_addr) && $stable(op_data)
                              && $stable(op_kind));

  // R10: a request only rises on the second write of an armed sequence
  p_start_needs_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> $past(pend_q != P_NONE && wr_stb));

  // R8: while running, other commands leave the sequencer untouched
  p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && st_q == ST_RUN && !eng_done && cmd != CMD_READ_STAT
      && cmd != CMD_SUSPEND |=> st_q == ST_RUN && pend_q == P_NONE);

  // R9: suspend is only entered from a running operation
  p_suspend_from_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_suspend) |-> $past(st_q == ST_RUN));
endmodule

// File: rtl/cui_mode_status.sv
`timescale 1ns/1ps
module cui_mode_status
  import flash_cui_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  rd_mode_e   mode_val,
  input  logic       set_err,
  input  logic       clr_err,
  input  logic       ready,
  input  logic       erase_held,
  input  logic       prog_held,
  output logic [1:0] rd_sel,
  output logic [7:0] status
);
  rd_mode_e mode_q;
  logic     err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= RD_ARRAY;
      err_q  <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_val;
      if (set_err)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  assign rd_sel = mode_q;
  assign status = {ready, erase_held, err_q, 2'b00, prog_held, 2'b00};

  // R5: a bad confirm leaves the error flagged and reads on status
  p_seq_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> status[5] && rd_sel == RD_STATUS);

  // R5: clear status removes the error flag
  p_clear_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err && !set_err |=> !status[5]);
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import flash_cui_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [1:0]    rd_sel,
  output logic [7:0]    status,
  output logic          op_valid,
  input  logic          op_ready,
  output logic          op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          op_suspend,
  input  logic          eng_done
);
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          mode_we;
  rd_mode_e      mode_val;
  logic          set_err;
  logic          clr_err;
  logic          ready;
  logic          erase_held;
  logic          prog_held;

  cui_bus_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  cui_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .op_ready   (op_ready),
    .eng_done   (eng_done),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_addr    (op_addr),
    .op_data    (op_data),
    .op_suspend (op_suspend),
    .mode_we    (mode_we),
    .mode_val   (mode_val),
    .set_err    (set_err),
    .clr_err    (clr_err),
    .ready      (ready),
    .erase_held (erase_held),
    .prog_held  (prog_held)
  );

  cui_mode_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_val   (mode_val),
    .set_err    (set_err),
    .clr_err    (clr_err),
    .ready      (ready),
    .erase_held (erase_held),
    .prog_held  (prog_held),
    .rd_sel     (rd_sel),
    .status     (status)
  );

  // R7: the status byte reads busy whenever a request is outstanding
  p_busy_when_requesting_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !status[7]);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    rd_sel;
  logic [7:0]    status;
  logic          op_valid;
  logic          op_ready = 1'b0;
  logic          op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          op_suspend;
  logic          eng_done = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .DW(DW)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rd_sel(rd_sel), .status(status),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .op_suspend(op_suspend),
    .eng_done(eng_done)
  );

  // {command byte, expected rd_sel, expected status}; op_valid must stay 0
  localparam int NVEC = 10;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h90, 2'd1, 8'h80}, {8'h98, 2'd3, 8'h80}, {8'h70, 2'd2, 8'h80},
    {8'hFF, 2'd0, 8'h80}, {8'h20, 2'd2, 8'h80}, {8'h33, 2'd2, 8'hA0},
    {8'h90, 2'd1, 8'hA0}, {8'h50, 2'd1, 8'h80}, {8'h12, 2'd1, 8'h80},
    {8'hFF, 2'd0, 8'h80}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_ready();
    @(negedge clk); op_ready = 1'b1;
    @(negedge clk); op_ready = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset outputs", {rd_sel, status, op_valid, op_suspend}, {2'd0, 8'h80, 1'b0, 1'b0});

    // vector table: mode commands, bad erase confirm, clear status
    for (int i = 0; i < NVEC; i++) begin
      bus_write('0, {8'h00, VEC[i][17:10]});
      chk("R3/R5/R10 vector", {rd_sel, status, op_valid}, {VEC[i][9:0], 1'b0});
    end

    // program sequence with back-pressure and busy filtering
    bus_write('0, 16'h0040);
    chk("R4 setup", {rd_sel, op_valid}, {2'd2, 1'b0});
    bus_write(20'h00005, 16'h1234);
    chk("R4 request", {op_valid, op_kind, op_addr, op_data}, {1'b1, 1'b0, 20'h00005, 16'h1234});
    chk("R7 busy status", {rd_sel, status}, {2'd2, 8'h00});
    repeat (3) @(negedge clk);
    chk("R6 hold", {op_valid, op_addr, op_data}, {1'b1, 20'h00005, 16'h1234});
    bus_write('0, 16'h00FF);
    chk("R8 ignore FF busy", {rd_sel, op_valid}, {2'd2, 1'b1});
    pulse_ready();
    chk("R6 accepted", op_valid, 1'b0);
    bus_write('0, 16'h0090);
    chk("R8 ignore 90 busy", rd_sel, 2'd2);
    bus_write('0, 16'h0020);
    bus_write('0, 16'h00D0);
    chk("R8 no erase busy", {op_valid, status}, {1'b0, 8'h00});
    pulse_done();
    chk("R7 done keeps status", {rd_sel, status}, {2'd2, 8'h80});
    bus_write('0, 16'h00FF);
    chk("R7 FF returns array", rd_sel, 2'd0);

    // chip enable ends the cycle first, write enable held low one more cycle
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; wdata = 16'h0020;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    chk("R2 ce edge single capture", {rd_sel, status, op_valid}, {2'd2, 8'h80, 1'b0});
    bus_write(20'h00007, 16'h00D0);
    chk("R5 erase request", {op_valid, op_kind, op_addr}, {1'b1, 1'b1, 20'h00007});
    pulse_ready();
    bus_write('0, 16'h00B0);
    chk("R9 erase suspended", {op_suspend, status, rd_sel}, {1'b1, 8'hC0, 2'd2});
    bus_write('0, 16'h00FF);
    chk("R9 read array in suspend", rd_sel, 2'd0);
    bus_write('0, 16'h0020);
    chk("R9 erase setup ignored", {rd_sel, status}, {2'd0, 8'hC0});
    bus_write('0, 16'h0040);
    chk("R9 nested setup", rd_sel, 2'd2);
    bus_write(20'h00009, 16'h0055);
    chk("R9 nested request", {op_valid, op_kind, op_addr, op_data, status, op_suspend},
        {1'b1, 1'b0, 20'h00009, 16'h0055, 8'h40, 1'b1});
    pulse_ready();
    pulse_done();
    chk("R9 back to held erase", {status, op_suspend, op_valid}, {8'hC0, 1'b1, 1'b0});
    bus_write('0, 16'h00D0);
    chk("R9 resume", {op_suspend, status, rd_sel}, {1'b0, 8'h00, 2'd2});
    pulse_done();
    chk("R7 erase done", status, 8'h80);

    // output enable low during a write: no effect
    bus_write('0, 16'h00FF);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; wdata = 16'h0090;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 oe low ignored", {rd_sel, status}, {2'd0, 8'h80});

    // program suspend: no nested program allowed
    bus_write('0, 16'h0040);
    bus_write(20'h00003, 16'hABCD);
    pulse_ready();
    bus_write('0, 16'h00B0);
    chk("R9 program suspended", {status, op_suspend}, {8'h84, 1'b1});
    bus_write('0, 16'h00FF);
    bus_write('0, 16'h0040);
    chk("R9 program setup ignored", {rd_sel, status, op_valid}, {2'd0, 8'h84, 1'b0});
    bus_write('0, 16'h00D0);
    chk("R9 program resume", {status, rd_sel, op_suspend}, {8'h00, 2'd2, 1'b0});
    pulse_done();
    chk("R7 program done", status, 8'h80);

    // reset in the middle of a request
    bus_write('0, 16'h0040);
    bus_write(20'h00001, 16'h0001);
    do_reset();
    chk("R1 reset mid operation", {rd_sel, status, op_valid, op_suspend}, {2'd0, 8'h80, 1'b0, 1'b0});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule